// File: doc/BRIEF.md
# Microcoded Multicycle Processor Controller

This block is a small multicycle processor core whose control comes from a stored micro-program rather than a combinational decoder. A micro-program counter (the state of the controller) selects one word of an internal read-only control store each cycle. Each word drives the datapath control lines and says how to pick the next micro-address: fall through to the following word, jump through an opcode dispatch table, or return to the fetch word. The datapath holds an instruction register, two operand registers, an ALU result register, a memory data register, the program counter, a 32-entry register file and one shared adder/subtractor.

Instruction and data memories sit outside the block with combinational read and synchronous write. The block supports register add, register subtract, word load, word store and branch-if-equal. Every instruction begins with the same two micro-steps: fetch, then a shared decode that also precomputes the branch target.

The micro-program states (micro-addresses) are FETCH, DECODE, BEQ, LW_ADDR, LW_READ, LW_WB, SW_ADDR, SW_WRITE, ADD_EXE, ADD_WB, SUB_EXE, SUB_WB and NOP. The transitions are:
- FETCH to DECODE.
- DECODE dispatches to BEQ, LW_ADDR, SW_ADDR, ADD_EXE, SUB_EXE or NOP.
- LW_ADDR to LW_READ to LW_WB.
- SW_ADDR to SW_WRITE.
- ADD_EXE to ADD_WB.
- SUB_EXE to SUB_WB.
- BEQ, LW_WB, SW_WRITE, ADD_WB, SUB_WB and NOP all return to FETCH.

Top module: `ucode_ctrl_core`

## Requirements
- R1: While reset is asserted (rst_n low, asynchronous), the program counter and micro-PC are 0, instr_done is 0 and dmem_we is 0. The first fetch after release reads address 0.
- R2: Each instruction fetches the word at the PC and sets PC to PC+4, then runs a shared decode step. Instruction fields are op[31:26], rs[25:21], rt[20:16], rd[15:11], funct[5:0] and imm[15:0], with imm sign-extended. Total cycles per instruction are BEQ 3, ADD 4, SUB 4, SW 4, LW 5, and 3 for any unrecognized encoding.
- R3: With op 0x00, funct 0x20 writes rs+rt to rd and funct 0x22 writes rs-rt to rd, both modulo 2^32.
- R4: Op 0x23 (load) asserts dmem_re for exactly one cycle at address rs+imm and writes the word read into rt.
- R5: Op 0x2B (store) asserts dmem_we for exactly one cycle, with address rs+imm and write data rt. dmem_re is never high together with dmem_we.
- R6: Op 0x04 (branch) compares rs and rt. If they are equal, the next fetch is at PC+4+(imm<<2); otherwise it is at PC+4.
- R7: Register 0 always reads as zero, and writes to it are discarded.
- R8: Any other op value, and op 0x00 with any other funct, retires after fetch and decode with no register or memory effect, and the next fetch is at PC+4.
- R9: instr_done is high for exactly one cycle, the last micro-step of each instruction. The following cycle is a fetch.
- R10: The PC is always word aligned and changes only at the end of the fetch step or the branch step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | 32 | Instruction address (the PC) |
| imem_rdata | input | 32 | Instruction word at imem_addr |
| dmem_addr | output | 32 | Data address (ALU result register) |
| dmem_wdata | output | 32 | Store data (operand register B) |
| dmem_rdata | input | 32 | Load data at dmem_addr |
| dmem_re | output | 1 | Data read strobe |
| dmem_we | output | 1 | Data write strobe |
| instr_done | output | 1 | One-cycle pulse in each instruction's final micro-step |

## Verification
The micro-PC is hidden, so a wrong micro-address shows at the ports through instr_done spacing, memory strobes and the PC. A bad dispatch or sequencing step alters the cycle count of that same instruction, which is checked at its instr_done pulse. A mis-set PC shows on imem_addr one cycle after the pulse. A corrupted register value stays hidden until a later store or branch exposes it. For that reason, every store is compared against an instruction-level model at the cycle it happens, and the whole data memory is compared at the end.

// File: rtl/ucode_pkg.sv
package ucode_pkg;

    localparam int XLEN_DEF  = 32;
    localparam int REG_IDX_W = 5;
    localparam int NREGS     = 1 << REG_IDX_W;
    localparam int UADDR_W   = 4;

    localparam logic [5:0] OP_RTYPE = 6'h00;
    localparam logic [5:0] OP_BEQ   = 6'h04;
    localparam logic [5:0] OP_LW    = 6'h23;
    localparam logic [5:0] OP_SW    = 6'h2B;
    localparam logic [5:0] FN_ADD   = 6'h20;
    localparam logic [5:0] FN_SUB   = 6'h22;

    typedef enum logic [UADDR_W-1:0] {
        UA_FETCH, UA_DECODE, UA_BEQ,
        UA_LW_ADDR, UA_LW_READ, UA_LW_WB,
        UA_SW_ADDR, UA_SW_WRITE,
        UA_ADD_EXE, UA_ADD_WB,
        UA_SUB_EXE, UA_SUB_WB,
        UA_NOP
    } uaddr_e;

    typedef enum logic       {SA_PC, SA_A} src_a_e;
    typedef enum logic [1:0] {SB_B, SB_FOUR, SB_IMM, SB_OFF} src_b_e;
    typedef enum logic       {FN_PLUS, FN_MINUS} alu_fun_e;
    typedef enum logic [1:0] {PS_HOLD, PS_ALU, PS_ALUOUT} pc_src_e;
    typedef enum logic [1:0] {NX_SEQ, NX_DISPATCH, NX_FETCH} next_e;

    typedef struct packed {
        src_a_e   src_a;
        src_b_e   src_b;
        alu_fun_e alu_fun;
        logic     reg_we;
        logic     dst_rd;
        logic     wb_mdr;
        logic     mem_rd;
        logic     mem_wr;
        logic     ir_we;
        pc_src_e  pc_src;
        logic     cond;
    } dp_ctl_t;

endpackage

// File: rtl/ucode_rom.sv
module ucode_rom
    import ucode_pkg::*;
(
    input  uaddr_e  upc,
    output dp_ctl_t ctl,
    output next_e   nxt
);

    always_comb begin
        ctl = '0;
        nxt = NX_SEQ;
        unique case (upc)
            UA_FETCH: begin
                ctl.ir_we  = 1'b1;
                ctl.src_b  = SB_FOUR;
                ctl.pc_src = PS_ALU;
            end
            UA_DECODE: begin
                ctl.src_b = SB_OFF;
                nxt       = NX_DISPATCH;
            end
            UA_BEQ: begin
                ctl.src_a   = SA_A;
                ctl.alu_fun = FN_MINUS;
                ctl.pc_src  = PS_ALUOUT;
                ctl.cond    = 1'b1;
                nxt         = NX_FETCH;
            end
            UA_LW_ADDR, UA_SW_ADDR: begin
                ctl.src_a = SA_A;
                ctl.src_b = SB_IMM;
            end
            UA_LW_READ: ctl.mem_rd = 1'b1;
            UA_LW_WB: begin
                ctl.reg_we = 1'b1;
                ctl.wb_mdr = 1'b1;
                nxt        = NX_FETCH;
            end
            UA_SW_WRITE: begin
                ctl.mem_wr = 1'b1;
                nxt        = NX_FETCH;
            end
            UA_ADD_EXE: ctl.src_a = SA_A;
            UA_SUB_EXE: begin
                ctl.src_a   = SA_A;
                ctl.alu_fun = FN_MINUS;
            end
            UA_ADD_WB, UA_SUB_WB: begin
                ctl.reg_we = 1'b1;
                ctl.dst_rd = 1'b1;
                nxt        = NX_FETCH;
            end
            UA_NOP: nxt = NX_FETCH;
            default: nxt = NX_FETCH;
        endcase
    end

endmodule

// File: rtl/ucode_seq.sv
module ucode_seq
    import ucode_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  next_e       nxt,
    input  logic [5:0]  opcode,
    input  logic [5:0]  funct,
    output uaddr_e      upc,
    output logic        done
);

    uaddr_e upc_nxt;
    uaddr_e disp;

    always_comb begin
        unique case (opcode)
            OP_BEQ: disp = UA_BEQ;
            OP_LW:  disp = UA_LW_ADDR;
            OP_SW:  disp = UA_SW_ADDR;
            OP_RTYPE: begin
                if (funct == FN_ADD)      disp = UA_ADD_EXE;
                else if (funct == FN_SUB) disp = UA_SUB_EXE;
                else                      disp = UA_NOP;
            end
            default: disp = UA_NOP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) upc <= UA_FETCH;
        else        upc <= upc_nxt;
    end

    always_comb begin
        done = 1'b0;
        unique case (nxt)
            NX_SEQ:      upc_nxt = uaddr_e'(4'(upc + 4'd1));
            NX_DISPATCH: upc_nxt = disp;
            NX_FETCH: begin
                upc_nxt = UA_FETCH;
                done    = 1'b1;
            end
            default:     upc_nxt = UA_FETCH;
        endcase
    end

endmodule

// File: rtl/ucode_datapath.sv
module ucode_datapath
    import ucode_pkg::*;
#(
    parameter int XLEN = XLEN_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  dp_ctl_t         ctl,
    input  logic [31:0]     imem_rdata,
    input  logic [XLEN-1:0] dmem_rdata,
    output logic [31:0]     ir,
    output logic [XLEN-1:0] pc,
    output logic [XLEN-1:0] aluout,
    output logic [XLEN-1:0] b_q
);

    logic [XLEN-1:0] rf [NREGS];
    logic [XLEN-1:0] a_q, mdr, alu_a, alu_b, alu_y, sext, wb_data;
    logic [REG_IDX_W-1:0] rs, rt, rd, dst;
    logic zero, pc_en;

    assign rs   = ir[25:21];
    assign rt   = ir[20:16];
    assign rd   = ir[15:11];
    assign sext = {{(XLEN-16){ir[15]}}, ir[15:0]};

    always_comb begin
        alu_a = (ctl.src_a == SA_A) ? a_q : pc;
        unique case (ctl.src_b)
            SB_B:    alu_b = b_q;
            SB_FOUR: alu_b = XLEN'(4);
            SB_IMM:  alu_b = sext;
            SB_OFF:  alu_b = sext << 2;
            default: alu_b = b_q;
        endcase
        alu_y = (ctl.alu_fun == FN_MINUS) ? alu_a - alu_b : alu_a + alu_b;
        zero  = (alu_y == '0);
        pc_en = (ctl.pc_src != PS_HOLD) && (!ctl.cond || zero);
        dst     = ctl.dst_rd ? rd : rt;
        wb_data = ctl.wb_mdr ? mdr : aluout;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ir     <= '0;
            pc     <= '0;
            a_q    <= '0;
            b_q    <= '0;
            aluout <= '0;
            mdr    <= '0;
        end else begin
            if (ctl.ir_we) ir <= imem_rdata;
            a_q    <= (rs == '0) ? '0 : rf[rs];
            b_q    <= (rt == '0) ? '0 : rf[rt];
            aluout <= alu_y;
            if (ctl.mem_rd) mdr <= dmem_rdata;
            if (pc_en) pc <= (ctl.pc_src == PS_ALUOUT) ? aluout : alu_y;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) rf[i] <= '0;
        end else if (ctl.reg_we && dst != '0) begin
            rf[dst] <= wb_data;
        end
    end

endmodule

// File: rtl/ucode_ctrl_core.sv
module ucode_ctrl_core
    import ucode_pkg::*;
#(
    parameter int XLEN = XLEN_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [XLEN-1:0] imem_addr,
    input  logic [31:0]     imem_rdata,
    output logic [XLEN-1:0] dmem_addr,
    output logic [XLEN-1:0] dmem_wdata,
    input  logic [XLEN-1:0] dmem_rdata,
    output logic            dmem_re,
    output logic            dmem_we,
    output logic            instr_done
);

    uaddr_e      upc;
    dp_ctl_t     ctl;
    next_e       nxt;
    logic [31:0] ir;

    ucode_rom rom_i (
        .upc (upc),
        .ctl (ctl),
        .nxt (nxt)
    );

    ucode_seq seq_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .nxt    (nxt),
        .opcode (ir[31:26]),
        .funct  (ir[5:0]),
        .upc    (upc),
        .done   (instr_done)
    );

    ucode_datapath #(.XLEN(XLEN)) dp_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl        (ctl),
        .imem_rdata (imem_rdata),
        .dmem_rdata (dmem_rdata),
        .ir         (ir),
        .pc         (imem_addr),
        .aluout     (dmem_addr),
        .b_q        (dmem_wdata)
    );

    assign dmem_re = ctl.mem_rd;
    assign dmem_we = ctl.mem_wr;

endmodule

// File: rtl/ucode_ctrl_chk.sv
module ucode_ctrl_chk
    import ucode_pkg::*;
#(
    parameter int XLEN = XLEN_DEF
) (
    input logic            clk,
    input logic            rst_n,
    input uaddr_e          upc,
    input logic [XLEN-1:0] imem_addr,
    input logic            dmem_re,
    input logic            dmem_we,
    input logic            instr_done
);

    AST_MEM_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(dmem_we && dmem_re)); // R5
    AST_FETCH_THEN_DECODE: assert property (@(posedge clk) disable iff (!rst_n) (upc == UA_FETCH) |=> (upc == UA_DECODE)); // R2
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) instr_done |=> !instr_done); // R9
    AST_DONE_TO_FETCH: assert property (@(posedge clk) disable iff (!rst_n) instr_done |=> (upc == UA_FETCH)); // R9
    AST_PC_HELD: assert property (@(posedge clk) disable iff (!rst_n) (upc != UA_FETCH && upc != UA_BEQ) |=> $stable(imem_addr)); // R10
    AST_PC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n) imem_addr[1:0] == 2'b00); // R10

endmodule

bind ucode_ctrl_core ucode_ctrl_chk #(.XLEN(XLEN)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .upc        (upc),
    .imem_addr  (imem_addr),
    .dmem_re    (dmem_re),
    .dmem_we    (dmem_we),
    .instr_done (instr_done)
);

// File: tb/ucode_ctrl_core_tb_top.sv
`timescale 1ns/100ps
module ucode_ctrl_core_tb_top;

    localparam int PROG_LEN = 140;
    localparam int WDOG     = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_re, dmem_we, instr_done;

    logic [31:0] imem [256];
    logic [31:0] dmem [64];
    logic [31:0] mreg [32];
    logic [31:0] mdm  [64];
    logic [31:0] mpc;
    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    assign imem_rdata = imem[imem_addr[9:2]];
    assign dmem_rdata = dmem[dmem_addr[7:2]];
    always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;

    ucode_ctrl_core dut_i (
        .clk(clk), .rst_n(rst_n),
        .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata),
        .dmem_re(dmem_re), .dmem_we(dmem_we), .instr_done(instr_done)
    );

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
        return {op, 5'(rs), 5'(rt), 16'(imm)};
    endfunction

    function automatic logic [31:0] sx(logic [31:0] ins);
        return {{16{ins[15]}}, ins[15:0]};
    endfunction

    function automatic int kind(logic [31:0] ins);  // 0 nop 1 add 2 sub 3 lw 4 sw 5 beq
        case (ins[31:26])
            6'h00:   return (ins[5:0] == 6'h20) ? 1 : (ins[5:0] == 6'h22) ? 2 : 0;
            6'h23:   return 3;
            6'h2B:   return 4;
            6'h04:   return 5;
            default: return 0;
        endcase
    endfunction

    function automatic int exp_cycles(int k);
        case (k)
            1, 2, 4: return 4;
            3:       return 5;
            default: return 3;
        endcase
    endfunction

    function automatic string kind_tag(int k);
        case (k)
            1, 2:    return "R3";
            3:       return "R4";
            4:       return "R5";
            5:       return "R6";
            default: return "R8";
        endcase
    endfunction

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic model_step();
        logic [31:0] ins, a, b;
        int k;
        ins = imem[mpc[9:2]];
        a = mreg[ins[25:21]];
        b = mreg[ins[20:16]];
        k = kind(ins);
        case (k)
            1: if (ins[15:11] != 0) mreg[ins[15:11]] = a + b;
            2: if (ins[15:11] != 0) mreg[ins[15:11]] = a - b;
            3: if (ins[20:16] != 0) mreg[ins[20:16]] = mdm[5'(0) + 6'((a + sx(ins)) >> 2)];
            4: mdm[6'((a + sx(ins)) >> 2)] = b;
            default: ;
        endcase
        if (k == 5 && a == b) mpc = mpc + 32'd4 + (sx(ins) << 2);
        else                  mpc = mpc + 32'd4;
    endtask

    initial begin : wdog
        repeat (WDOG + 1000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        int cyc, re_cnt, we_cnt, guard, k;
        bit pc_check, prev_done;
        logic [31:0] pc_mid, ins, ea;
        void'($urandom(32'd20240611));

        for (int i = 0; i < 256; i++) imem[i] = {6'h3F, 26'd0};
        for (int i = 0; i < 64; i++) begin
            dmem[i] = $urandom;
        end
        for (int i = 0; i < 32; i++) mreg[i] = '0;
        dmem[0] = 32'hA5A5_0001;
        dmem[2] = 32'h7FFF_FFFF;
        dmem[3] = 32'h0000_0001;
        dmem[7] = 32'h0000_0040;

        // directed corner cases
        imem[0]  = enc_i(6'h23, 0, 1, 8);      // r1 = 7fffffff
        imem[1]  = enc_i(6'h23, 0, 2, 12);     // r2 = 1
        imem[2]  = enc_r(1, 2, 3, 6'h20);      // r3 = 80000000 (wrap)
        imem[3]  = enc_i(6'h2B, 0, 3, 16);     // dmem[4]
        imem[4]  = enc_r(0, 2, 4, 6'h22);      // r4 = ffffffff
        imem[5]  = enc_i(6'h2B, 0, 4, 20);     // dmem[5]
        imem[6]  = enc_r(1, 2, 0, 6'h20);      // write to r0 dropped
        imem[7]  = enc_i(6'h2B, 0, 0, 24);     // dmem[6] = 0
        imem[8]  = enc_i(6'h23, 0, 5, 28);     // r5 = 64
        imem[9]  = enc_i(6'h2B, 5, 1, -4);     // dmem[15] via negative offset
        imem[10] = enc_i(6'h04, 1, 1, 1);      // taken, skips 11
        imem[11] = enc_i(6'h2B, 0, 1, 0);      // must not run
        imem[12] = enc_i(6'h04, 1, 2, 1);      // not taken
        imem[13] = {6'h3F, 26'h155};           // unknown opcode
        imem[14] = enc_r(1, 2, 6, 6'h25);      // unknown funct, r6 stays 0
        imem[15] = enc_i(6'h2B, 0, 6, 32);     // dmem[8] = 0

        // constrained random body
        for (int i = 16; i < PROG_LEN; i++) begin
            int sel, rs, rt, rd;
            sel = int'($urandom % 6);
            rs = int'($urandom % 8);
            rt = int'($urandom % 8);
            rd = int'($urandom % 8);
            case (sel)
                0: imem[i] = enc_r(rs, rt, rd, 6'h20);
                1: imem[i] = enc_r(rs, rt, rd, 6'h22);
                2: imem[i] = enc_i(6'h23, 0, rt, 4 * int'($urandom % 64));
                3: imem[i] = enc_i(6'h2B, 0, rt, 4 * (16 + int'($urandom % 48)));
                4: imem[i] = enc_i(6'h04, rs, (($urandom % 3) == 0) ? rs : rt, int'($urandom % 4));
                default: imem[i] = {6'(1 + ($urandom % 3)), 26'($urandom)};
            endcase
        end
        for (int i = 0; i < 64; i++) mdm[i] = dmem[i];
        mpc = '0;

        // R1 reset state
        repeat (3) begin
            @(negedge clk);
            chk(imem_addr == 0, "R1", "pc in reset", imem_addr, 0);
            chk(instr_done == 0, "R1", "instr_done in reset", 32'(instr_done), 0);
            chk(dmem_we == 0, "R1", "dmem_we in reset", 32'(dmem_we), 0);
        end
        rst_n = 1'b1;
        #0.5;
        chk(imem_addr == 0, "R1", "first fetch address", imem_addr, 0);

        cyc = 0; re_cnt = 0; we_cnt = 0; guard = 0;
        pc_check = 0; prev_done = 0; pc_mid = '0;
        while (mpc < 4 * PROG_LEN && guard < WDOG) begin
            ins = imem[mpc[9:2]];
            k = kind(ins);
            cyc++;
            if (pc_check) begin
                chk(imem_addr == mpc, "R9", "fetch address after done", imem_addr, mpc);
                pc_check = 0;
            end
            if (cyc == 2) begin
                pc_mid = imem_addr;
                chk(imem_addr == mpc + 4, "R2", "pc after fetch", imem_addr, mpc + 4);
            end else if (cyc > 2) begin
                chk(imem_addr == pc_mid, "R10", "pc held mid instruction", imem_addr, pc_mid);
            end
            if (dmem_re) re_cnt++;
            if (dmem_we) begin
                we_cnt++;
                ea = mreg[ins[25:21]] + sx(ins);
                chk(k == 4, "R5", "write strobe outside store", 32'(k), 4);
                chk(dmem_addr == ea, "R5", "store address", dmem_addr, ea);
                chk(dmem_wdata == mreg[ins[20:16]], (ins[20:16] == 0) ? "R7" : "R5",
                    "store data", dmem_wdata, mreg[ins[20:16]]);
                chk(!dmem_re, "R5", "read with write", 32'(dmem_re), 0);
            end
            if (instr_done) begin
                chk(!prev_done, "R9", "done in consecutive cycles", 1, 0);
                chk(cyc == exp_cycles(k), "R2", {kind_tag(k), " cycle count"}, 32'(cyc), 32'(exp_cycles(k)));
                chk(re_cnt == ((k == 3) ? 1 : 0), "R4", "read strobe cycles", 32'(re_cnt), (k == 3) ? 1 : 0);
                chk(we_cnt == ((k == 4) ? 1 : 0), "R5", "write strobe cycles", 32'(we_cnt), (k == 4) ? 1 : 0);
                model_step();
                cyc = 0; re_cnt = 0; we_cnt = 0;
                pc_check = 1;
            end
            prev_done = instr_done;
            @(negedge clk);
            guard++;
        end
        if (guard >= WDOG) begin
            fails++;
            $display("FAIL watchdog expired in main loop");
        end
        if (pc_check) chk(imem_addr == mpc, "R6", "final fetch address", imem_addr, mpc);

        // directed results
        chk(dmem[4] == 32'h8000_0000, "R3", "add wraps", dmem[4], 32'h8000_0000);
        chk(dmem[5] == 32'hFFFF_FFFF, "R3", "sub from zero", dmem[5], 32'hFFFF_FFFF);
        chk(dmem[6] == 32'h0, "R7", "r0 stays zero", dmem[6], 0);
        chk(dmem[15] == 32'h7FFF_FFFF, "R4", "negative offset", dmem[15], 32'h7FFF_FFFF);
        chk(dmem[0] == 32'hA5A5_0001, "R6", "taken branch skips store", dmem[0], 32'hA5A5_0001);
        chk(dmem[8] == 32'h0, "R8", "unknown funct no write", dmem[8], 0);
        for (int i = 0; i < 64; i++)
            chk(dmem[i] == mdm[i], "R5", $sformatf("memory word %0d", i), dmem[i], mdm[i]);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule